// File: doc/BRIEF.md
# NAND Erased-Page Detector

This block sits beside the ECC read path of a NAND controller. Every raw byte of a page passes through it on its way to the data buffer, and it keeps a running count of the zero bits in that page. The ECC decoder reports one result per sector. When any sector of the page cannot be corrected, the block compares the page's zero count with a programmable threshold. It then reports one of two outcomes: the page is simply erased, or the page has a real uncorrectable error.

The block returns its outcome through sticky interrupt status bits. Software clears these bits by writing ones to them. A configuration word holds the correction strength and the erased threshold. A threshold of one more than the correction strength covers the worst case, in which all bitflips fall in a single sector. A threshold of zero turns erased detection off.

The data bytes leave the block unchanged, one cycle late. For an erased page the block does not fill the buffer with 0xFF; software must do that itself.

Top module: `erased_page_detect`

## Requirements
- R1: Every data beat adds its number of zero bits to a per-page counter. A `page_start` pulse restarts the counter from zero. A data beat in the same cycle as the pulse counts as the first beat of the new page.
- R2: If at least one sector of the page is flagged uncorrectable and the zero count is strictly less than the threshold, status bit 16 (erased) is set and status bit 0 (uncorrectable) is not set.
- R3: If at least one sector is flagged uncorrectable and the zero count is greater than or equal to the threshold, status bit 0 is set and status bit 16 is not set.
- R4: If no sector of the page is flagged uncorrectable, neither bit 0 nor bit 16 is set, whatever the zero count.
- R5: The configuration word holds the correction strength in bits [4:0] and the erased threshold in bits [31:16]. Every other bit reads back as zero. After reset the whole word reads zero.
- R6: While the threshold is zero, no page is ever reported as erased.
- R7: The zero counter saturates at its all-ones value (65535 by default) instead of wrapping.
- R8: The verdict is made exactly once per page. It is made when both the last data beat and the last sector result have arrived, in either order or in the same cycle. The status bits show the verdict in the cycle after the later of the two arrives, and not before.
- R9: Status bits are sticky. Writing a one to a status bit clears it, and writing a zero leaves it alone. If a set and a clear of the same bit happen in the same cycle, the set wins.
- R10: Every data beat appears on `out_valid`/`out_data` exactly one cycle later, with its value unchanged.
- R11: Status bit 15 (page transfer done) is set with every verdict. No other status bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word read back |
| sts_clr_we | input | 1 | Write strobe for clearing status bits |
| sts_clr_wdata | input | 32 | Ones mark the status bits to clear |
| irq_status | output | 32 | Sticky interrupt status word |
| page_start | input | 1 | Pulse that opens a new page |
| in_valid | input | 1 | Raw data beat valid |
| in_data | input | 8 | Raw data beat |
| in_last | input | 1 | Marks the last data beat of the page |
| sec_valid | input | 1 | Decoder result for one sector is valid |
| sec_uncorr | input | 1 | That sector is uncorrectable |
| sec_last | input | 1 | That sector is the last of the page |
| out_valid | output | 1 | Data beat valid, delayed |
| out_data | output | 8 | Data beat, unchanged |

## Verification
The assertions assume that every page opens with a `page_start` pulse and then carries exactly one data beat marked last and exactly one sector result marked last. They also assume the threshold is not rewritten while a page is in flight, because the check on the erased bit looks at the threshold one cycle back. The stimulus follows these rules. Each page is preceded by a lone `page_start` pulse. The bench builds the page to a fixed length with a single last marker on each stream. The configuration is written only between pages. The order of the two last markers is varied (data first, sectors first, or both in the same cycle), and so is the density of zeros in the data.

// File: rtl/edp_pkg.sv
package edp_pkg;

    // status word bit positions
    localparam int ST_UNC_BIT    = 0;
    localparam int ST_DONE_BIT   = 15;
    localparam int ST_ERASED_BIT = 16;

    // configuration word layout
    localparam int CFG_STR_W   = 5;
    localparam int CFG_THR_LSB = 16;
    localparam int CFG_THR_W   = 16;
    localparam int WORD_W      = 32;

    typedef struct packed {
        logic any_unc;
        logic sec_done;
        logic data_done;
        logic decided;
    } trk_state_t;

    typedef struct packed {
        logic [CFG_STR_W-1:0] strength;
        logic [CFG_THR_W-1:0] threshold;
    } cfg_state_t;

endpackage

// File: rtl/edp_zero_count.sv
module edp_zero_count #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             page_start_i,
    input  logic             valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int ZW = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [DATA_W-1:0] zero_bit;
    logic [ZW-1:0]     zeros;
    logic [CNT_W:0]    sum;
    logic [CNT_W-1:0]  base;
    logic [CNT_W-1:0]  cnt_d, cnt_q;

    // one inverter per lane
    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_lane
            assign zero_bit[g] = ~data_i[g];
        end
    endgenerate

    always_comb begin
        zeros = '0;
        for (int i = 0; i < DATA_W; i++) begin
            zeros = zeros + ZW'(zero_bit[i]);
        end
    end

    // next-state process
    always_comb begin
        base  = page_start_i ? '0 : cnt_q;
        sum   = {1'b0, base} + (CNT_W + 1)'(valid_i ? zeros : '0);
        cnt_d = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_next_o = cnt_d;
    assign cnt_o      = cnt_q;

    // R7: a saturated counter stays saturated until the next page
    assert_cnt_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !page_start_i) |=> cnt_q == CNT_MAX);

    // R1: without a page restart the count never shrinks
    assert_cnt_monotonic_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !page_start_i |=> cnt_q >= $past(cnt_q));

endmodule

// File: rtl/edp_sector_track.sv
module edp_sector_track
    import edp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic page_start_i,
    input  logic data_valid_i,
    input  logic data_last_i,
    input  logic sec_valid_i,
    input  logic sec_uncorr_i,
    input  logic sec_last_i,
    output logic decide_o,
    output logic any_unc_o
);
    trk_state_t st_d, st_q;
    trk_state_t base;

    always_comb begin
        base = st_q;
        if (page_start_i) base = '0;
        st_d = base;
        if (sec_valid_i) begin
            st_d.any_unc = base.any_unc | sec_uncorr_i;
            if (sec_last_i) st_d.sec_done = 1'b1;
        end
        if (data_valid_i && data_last_i) st_d.data_done = 1'b1;
        decide_o  = st_d.sec_done && st_d.data_done && !base.decided;
        if (decide_o) st_d.decided = 1'b1;
        any_unc_o = st_d.any_unc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: one verdict per page
    assert_single_decide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        decide_o |=> (!decide_o || page_start_i));

    // R8: no verdict before both streams have finished
    assert_decide_needs_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
        decide_o |=> (st_q.sec_done && st_q.data_done));

endmodule

// File: rtl/edp_cfg_regs.sv
module edp_cfg_regs
    import edp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [WORD_W-1:0]    wdata_i,
    output logic [WORD_W-1:0]    rdata_o,
    output logic [CFG_STR_W-1:0] strength_o,
    output logic [CFG_THR_W-1:0] threshold_o
);
    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d.strength  = wdata_i[CFG_STR_W-1:0];
            cfg_d.threshold = wdata_i[CFG_THR_LSB +: CFG_THR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata_o = '0;
        rdata_o[CFG_STR_W-1:0]              = cfg_q.strength;
        rdata_o[CFG_THR_LSB +: CFG_THR_W]   = cfg_q.threshold;
    end

    assign strength_o  = cfg_q.strength;
    assign threshold_o = cfg_q.threshold;

    // R5: without a write the word holds
    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(rdata_o));

endmodule

// File: rtl/erased_page_detect.sv
module erased_page_detect
    import edp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              sts_clr_we,
    input  logic [WORD_W-1:0] sts_clr_wdata,
    output logic [WORD_W-1:0] irq_status,
    input  logic              page_start,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              sec_valid,
    input  logic              sec_uncorr,
    input  logic              sec_last,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int CMP_W = (CNT_W > CFG_THR_W) ? CNT_W : CFG_THR_W;

    typedef struct packed {
        logic [WORD_W-1:0] sts;
        logic              ov;
        logic [DATA_W-1:0] od;
    } top_state_t;

    logic [CFG_STR_W-1:0] strength;
    logic [CFG_THR_W-1:0] threshold;
    logic [CNT_W-1:0]     cnt_next, cnt_cur;
    logic                 decide, any_unc, below;
    logic [WORD_W-1:0]    set_mask;
    top_state_t           s_d, s_q;

    edp_cfg_regs u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (cfg_we),
        .wdata_i     (cfg_wdata),
        .rdata_o     (cfg_rdata),
        .strength_o  (strength),
        .threshold_o (threshold)
    );

    edp_zero_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .page_start_i (page_start),
        .valid_i      (in_valid),
        .data_i       (in_data),
        .cnt_next_o   (cnt_next),
        .cnt_o        (cnt_cur)
    );

    edp_sector_track u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .page_start_i (page_start),
        .data_valid_i (in_valid),
        .data_last_i  (in_last),
        .sec_valid_i  (sec_valid),
        .sec_uncorr_i (sec_uncorr),
        .sec_last_i   (sec_last),
        .decide_o     (decide),
        .any_unc_o    (any_unc)
    );

    always_comb begin
        below    = CMP_W'(cnt_next) < CMP_W'(threshold);
        set_mask = '0;
        if (decide) begin
            set_mask[ST_DONE_BIT]   = 1'b1;
            set_mask[ST_ERASED_BIT] = any_unc && below;
            set_mask[ST_UNC_BIT]    = any_unc && !below;
        end
        s_d     = s_q;
        if (sts_clr_we) s_d.sts = s_q.sts & ~sts_clr_wdata;
        s_d.sts = s_d.sts | set_mask;
        s_d.ov  = in_valid;
        s_d.od  = in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_status = s_q.sts;
    assign out_valid  = s_q.ov;
    assign out_data   = s_q.od;

    // R2 / R3: erased and uncorrectable never appear together for one page
    assert_exclusive_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[ST_ERASED_BIT]) |-> !$rose(irq_status[ST_UNC_BIT]));

    // R6: a zero threshold never yields an erased verdict
    assert_thr_zero_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[ST_ERASED_BIT]) |-> $past(threshold) != '0);

    // R9: a set bit survives unless cleared
    assert_sticky_erased_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[ST_ERASED_BIT] && !(sts_clr_we && sts_clr_wdata[ST_ERASED_BIT]))
        |=> irq_status[ST_ERASED_BIT]);

    assert_sticky_unc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[ST_UNC_BIT] && !(sts_clr_we && sts_clr_wdata[ST_UNC_BIT]))
        |=> irq_status[ST_UNC_BIT]);

    // R11: a verdict bit never appears without page done
    assert_done_with_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_status[ST_ERASED_BIT]) || $rose(irq_status[ST_UNC_BIT]))
        |-> irq_status[ST_DONE_BIT]);

    // R10: data passes unchanged one cycle later
    assert_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_data == $past(in_data)));

endmodule

// File: tb/tb_erased_page_detect.sv
module tb_erased_page_detect;
    localparam time CLK_PERIOD = 10ns;
    localparam int  CMAX = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        sts_clr_we = 1'b0;
    logic [31:0] sts_clr_wdata = '0;
    logic [31:0] irq_status;
    logic        page_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        sec_valid = 1'b0;
    logic        sec_uncorr = 1'b0;
    logic        sec_last = 1'b0;
    logic        out_valid;
    logic [7:0]  out_data;

    int checks = 0;
    int errors = 0;
    int pt_err = 0;
    int thr    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    erased_page_detect dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .sts_clr_we(sts_clr_we), .sts_clr_wdata(sts_clr_wdata),
        .irq_status(irq_status),
        .page_start(page_start), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .sec_valid(sec_valid), .sec_uncorr(sec_uncorr),
        .sec_last(sec_last), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [31:0] exp_status(int zeros, bit unc, int t);
        logic [31:0] e = '0;
        int z = (zeros > CMAX) ? CMAX : zeros;
        e[15] = 1'b1;
        if (unc) begin
            if (z < t) e[16] = 1'b1;
            else       e[0]  = 1'b1;
        end
        return e;
    endfunction

    function automatic logic [7:0] gen_byte(int dens);
        case (dens)
            0: return 8'hFF;
            1: return 8'hFF & ~($urandom & $urandom & $urandom);
            2: return 8'($urandom);
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // advance to the next negedge, checking the pass-through of the beat driven before
    task automatic step();
        logic       pv = in_valid;
        logic [7:0] pd = in_data;
        @(negedge clk);
        if (pv && (out_valid !== 1'b1 || out_data !== pd)) pt_err++;
        cfg_we = 0; sts_clr_we = 0; page_start = 0;
        in_valid = 0; in_last = 0; sec_valid = 0; sec_uncorr = 0; sec_last = 0;
    endtask

    task automatic write_cfg(logic [31:0] w);
        step(); cfg_we = 1; cfg_wdata = w;
        thr = int'(w[31:16]);
        step();
    endtask

    // order 0: data then sectors, 1: sectors then data, 2: sectors end with data
    task automatic run_page(int len, int nsec, int unc_idx, int order, int dens,
                            bit clr_end, string tag);
        int  zeros = 0;
        int  total;
        bit  unc = (unc_idx >= 0);
        step(); sts_clr_we = 1; sts_clr_wdata = '1;
        step(); page_start = 1;
        total = (order == 2) ? len : len + nsec;
        for (int c = 0; c < total; c++) begin
            int bi = -1;
            int si = -1;
            step();
            if (c == total - 1)
                check({tag, " R8 early"}, {31'b0, irq_status[15]}, 32'h0);
            case (order)
                0: begin if (c < len) bi = c; else si = c - len; end
                1: begin if (c < nsec) si = c; else bi = c - nsec; end
                default: begin bi = c; if (c >= len - nsec) si = c - (len - nsec); end
            endcase
            if (bi >= 0) begin
                in_valid = 1; in_data = gen_byte(dens); in_last = (bi == len - 1);
                zeros += 8 - $countones(in_data);
            end
            if (si >= 0) begin
                sec_valid = 1; sec_uncorr = (si == unc_idx); sec_last = (si == nsec - 1);
            end
            if (clr_end && c == total - 1) begin
                sts_clr_we = 1; sts_clr_wdata = '1;
            end
        end
        step();
        check(tag, irq_status, exp_status(zeros, unc, thr));
        check({tag, " R10 passthrough"}, pt_err, 0);
        pt_err = 0;
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7734));
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        check("R5 reset cfg", cfg_rdata, 32'h0);
        check("R9 reset status", irq_status, 32'h0);

        // R5: field layout
        write_cfg(32'hFFFF_FFFF);
        check("R5 layout", cfg_rdata, 32'hFFFF_001F);
        write_cfg(32'h0000_0000);

        // R6: threshold zero disables erased detection even with zero zeros
        run_page(16, 2, 0, 0, 0, 0, "R6 thr0");

        // strength 8, threshold 9
        write_cfg(32'h0009_0008);
        check("R5 readback", cfg_rdata, 32'h0009_0008);
        run_page(16, 4, 1, 0, 0, 0, "R2 erased");
        run_page(16, 4, 3, 1, 3, 0, "R3 uncorr");
        run_page(16, 4, -1, 2, 3, 0, "R4 no unc");
        run_page(12, 3, 2, 2, 0, 0, "R8 same cycle");

        // R2 / R3 boundary: exactly 8 and 9 zeros with threshold 9
        write_cfg(32'h0009_0008);
        begin
            step(); sts_clr_we = 1; sts_clr_wdata = '1;
            step(); page_start = 1;
            step(); in_valid = 1; in_data = 8'h00;
            step(); sec_valid = 1; sec_uncorr = 1; sec_last = 1;
            step(); in_valid = 1; in_data = 8'hFE; in_last = 1;
            step();
            check("R3 boundary count=thr", irq_status, 32'h0000_8001);
            step(); sts_clr_we = 1; sts_clr_wdata = '1;
            step(); page_start = 1; in_valid = 1; in_data = 8'h00;
            step(); sec_valid = 1; sec_uncorr = 1; sec_last = 1;
            step(); in_valid = 1; in_data = 8'hFF; in_last = 1;
            step();
            check("R1 R2 boundary count=thr-1", irq_status, 32'h0001_8000);
        end

        // R9: partial clear leaves other bits; set wins over clear
        step(); sts_clr_we = 1; sts_clr_wdata = 32'h0000_8000;
        step();
        check("R9 partial clear", irq_status, 32'h0001_0000);
        run_page(8, 2, 0, 0, 0, 1, "R9 set wins");
        step(); sts_clr_we = 1; sts_clr_wdata = 32'h0001_0000;
        step();
        check("R11 R9 clear erased", irq_status, 32'h0000_8000);

        // R7: saturation, 8200 all-zero bytes = 65600 zeros
        write_cfg(32'hFFFF_0010);
        run_page(8200, 1, 0, 0, 3, 0, "R7 saturate");

        // random pages
        for (int p = 0; p < 40; p++) begin
            int s    = $urandom_range(0, 31);
            int t    = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 200) : s + 1;
            int len  = $urandom_range(4, 40);
            int ns   = $urandom_range(1, 4);
            int ui   = ($urandom_range(0, 2) == 0) ? -1 : $urandom_range(0, ns - 1);
            int ord  = $urandom_range(0, 2);
            int dens = $urandom_range(0, 3);
            write_cfg({16'(t), 11'b0, 5'(s)});
            run_page(len, ns, ui, ord, dens, 0, "R1 R2 R3 R4 R8 R11 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule